// File: doc/BRIEF.md
# Programmable Bus Wait-State Generator

This block decides how many bus-clock cycles each CPU bus access lasts. A request names a target region, a direction and whether the external bus runs address and data over shared pins. The block works out the effective number of wait cycles from the configuration fields it holds and from a set of fixed minimum rules. It then counts the access out, reports which part of the access is under way, and strobes completion in the final cycle. Address decoding, memory strobe generation and pin drivers are handled elsewhere.

The request side uses a valid/ready handshake. The requester holds `req_valid` and its attributes steady until `req_ready` is seen high at a clock edge. `req_ready` is high only while no access is in progress. It falls for the whole access and rises again in the cycle after `acc_done`, so two accesses are always separated by one idle cycle. An external `hold_off` input can stretch any access once its programmed waits have run out. The configuration fields are loaded all at once by `cfg_we`. A load changes only accesses that are accepted after it.

Top module: `bus_wait_gen`

## Requirements
- R1: After reset, `req_ready`=1, `acc_done`=0 and `acc_phase`=0. Every wait field resets to its maximum, so a read of any external area takes 4 cycles, an internal access takes 2 and a register-area access takes 3.
- R2: Region codes 0..3 select external areas 0..3. The wait field of area k sits at `cfg_ext_waits[2k+1:2k]`. An external read with field value w lasts 1+w cycles.
- R3: An external write waits at least one cycle. With field 0 it lasts 2 cycles; with larger fields it lasts 1+w cycles.
- R4: When `req_mux`=1 on an external region, the access waits at least two cycles. Fields 0 and 1 give 3 cycles and field 3 gives 4. This holds for reads and writes.
- R5: Region code 4 is internal memory. It lasts 1+`cfg_int_wait` cycles, whatever the values of `req_write` and `req_mux`.
- R6: Region code 5 is the register area. It lasts 2 cycles when `cfg_sfr_wait`=0 and 3 cycles when it is 1.
- R7: A register-area access with `req_sfr_slow`=1 always lasts 3 cycles, even when `cfg_sfr_wait`=0.
- R8: The access length counts from the cycle after the accepting edge. `acc_done` is high for exactly one cycle, the last one. `req_ready` is low for the whole access and high in the following cycle.
- R9: While the programmed waits are over and `hold_off`=1, the access is extended with `acc_phase`=2 and no done strobe. It ends in the first cycle in which `hold_off`=0.
- R10: A configuration load during an access leaves that access's length unchanged. The next access uses the new values.
- R11: `acc_phase` encodes 0 for idle, 1 while programmed waits remain, 2 while held off, and 3 in the completing cycle.
- R12: Region codes 6 and 7 are unassigned and complete in 1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Block idle, request accepted at this edge |
| req_region | input | 3 | Target region code |
| req_write | input | 1 | 1 = write access |
| req_mux | input | 1 | External access uses the shared address/data bus |
| req_sfr_slow | input | 1 | Register access hits the always-slow subregion |
| hold_off | input | 1 | External request to stretch the access |
| cfg_we | input | 1 | Load all configuration fields |
| cfg_ext_waits | input | 8 | Four 2-bit external area wait fields |
| cfg_int_wait | input | 1 | Internal memory wait bit |
| cfg_sfr_wait | input | 1 | Register area wait bit |
| acc_done | output | 1 | Final cycle of the access |
| acc_phase | output | 2 | Current access phase |

## Verification
The bench targets the places where the minimum rules meet the programmed value. These are a zero-wait external write, the shared bus with fields 0, 1 and 3, and a slow register access with the wait bit clear. A design that added the forced minimums instead of taking the larger value would give these accesses the wrong length. Hold-off is tested both from the first cycle of a zero-wait access and after real waits. A design that tested hold-off too early or too late would show the wrong phase or the wrong length. A configuration load in the middle of an access would change that access's length if the count were not captured at acceptance. The bench also checks the done strobe for a second high cycle and for a missing idle cycle.

// File: rtl/bwg_pkg.sv
package bwg_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WAIT = 2'd1,
    PH_HOLD = 2'd2,
    PH_LAST = 2'd3
  } phase_e;
endpackage

// File: rtl/bwg_cfg_regs.sv
module bwg_cfg_regs #(
  parameter int N_EXT  = 4,
  parameter int WAIT_W = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [N_EXT*WAIT_W-1:0]   ext_in,
  input  logic                      int_in,
  input  logic                      sfr_in,
  output logic [N_EXT*WAIT_W-1:0]   ext_q,
  output logic                      int_q,
  output logic                      sfr_q
);
  // Slowest settings at reset so boot-time memories are always safe.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q <= '1;
      int_q <= 1'b1;
      sfr_q <= 1'b1;
    end else if (we) begin
      ext_q <= ext_in;
      int_q <= int_in;
      sfr_q <= sfr_in;
    end
  end
endmodule

// File: rtl/bwg_wait_calc.sv
module bwg_wait_calc #(
  parameter int N_EXT  = 4,
  parameter int WAIT_W = 2,
  parameter int RGN_W  = 3
) (
  input  logic [N_EXT*WAIT_W-1:0] ext_q,
  input  logic                    int_q,
  input  logic                    sfr_q,
  input  logic [RGN_W-1:0]        region,
  input  logic                    write,
  input  logic                    mux,
  input  logic                    sfr_slow,
  output logic [WAIT_W-1:0]       waits
);
  localparam int IDX_W = (N_EXT > 1) ? $clog2(N_EXT) : 1;
  localparam logic [RGN_W-1:0] RG_INT = RGN_W'(N_EXT);
  localparam logic [RGN_W-1:0] RG_SFR = RGN_W'(N_EXT + 1);
  localparam logic [WAIT_W-1:0] W_ONE = WAIT_W'(1);
  localparam logic [WAIT_W-1:0] W_TWO = WAIT_W'(2);

  logic [WAIT_W-1:0] fld [N_EXT];
  for (genvar g = 0; g < N_EXT; g++) begin : g_fld
    assign fld[g] = ext_q[g*WAIT_W +: WAIT_W];
  end

  logic [WAIT_W-1:0] ext_w, ext_wr, ext_mx;
  always_comb begin
    ext_w  = fld[region[IDX_W-1:0]];
    // Forced minimums combine as a maximum, never as a sum.
    ext_wr = (write && ext_w < W_ONE) ? W_ONE : ext_w;
    ext_mx = (mux && ext_wr < W_TWO) ? W_TWO : ext_wr;
  end

  always_comb begin
    if (region < RGN_W'(N_EXT))  waits = ext_mx;
    else if (region == RG_INT)   waits = WAIT_W'(int_q);
    else if (region == RG_SFR)   waits = (sfr_slow || sfr_q) ? W_TWO : W_ONE;
    else                         waits = '0;
  end
endmodule

// File: rtl/bwg_seq.sv
module bwg_seq #(
  parameter int WAIT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WAIT_W-1:0] load_waits,
  input  logic              hold_off,
  output logic              busy,
  output logic              done,
  output bwg_pkg::phase_e   phase
);
  import bwg_pkg::*;

  logic [WAIT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        cnt  <= load_waits;
      end
    end else if (cnt != '0) begin
      cnt <= cnt - WAIT_W'(1);
    end else if (!hold_off) begin
      busy <= 1'b0;
    end
  end

  always_comb begin
    if (!busy)          phase = PH_IDLE;
    else if (cnt != '0) phase = PH_WAIT;
    else if (hold_off)  phase = PH_HOLD;
    else                phase = PH_LAST;
    done = (phase == PH_LAST);
  end
endmodule

// File: rtl/bus_wait_gen.sv
module bus_wait_gen #(
  parameter int N_EXT  = 4,
  parameter int WAIT_W = 2,
  parameter int RGN_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [RGN_W-1:0]        req_region,
  input  logic                    req_write,
  input  logic                    req_mux,
  input  logic                    req_sfr_slow,
  input  logic                    hold_off,
  input  logic                    cfg_we,
  input  logic [N_EXT*WAIT_W-1:0] cfg_ext_waits,
  input  logic                    cfg_int_wait,
  input  logic                    cfg_sfr_wait,
  output logic                    acc_done,
  output logic [1:0]              acc_phase
);
  logic [N_EXT*WAIT_W-1:0] ext_q;
  logic                    int_q, sfr_q, busy, start;
  logic [WAIT_W-1:0]       eff_waits;
  bwg_pkg::phase_e         phase;

  bwg_cfg_regs #(.N_EXT(N_EXT), .WAIT_W(WAIT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we),
    .ext_in(cfg_ext_waits), .int_in(cfg_int_wait), .sfr_in(cfg_sfr_wait),
    .ext_q(ext_q), .int_q(int_q), .sfr_q(sfr_q)
  );

  bwg_wait_calc #(.N_EXT(N_EXT), .WAIT_W(WAIT_W), .RGN_W(RGN_W)) u_calc (
    .ext_q(ext_q), .int_q(int_q), .sfr_q(sfr_q),
    .region(req_region), .write(req_write), .mux(req_mux),
    .sfr_slow(req_sfr_slow), .waits(eff_waits)
  );

  assign req_ready = !busy;
  assign start     = req_valid && req_ready;

  bwg_seq #(.WAIT_W(WAIT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .load_waits(eff_waits),
    .hold_off(hold_off), .busy(busy), .done(acc_done), .phase(phase)
  );

  assign acc_phase = phase;
endmodule

// File: rtl/bwg_checker.sv
module bwg_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       hold_off,
  input logic       acc_done,
  input logic [1:0] acc_phase
);
  import bwg_pkg::*;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_done |=> (!acc_done && req_ready)); // R8
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_ready && acc_phase != PH_IDLE)); // R8
  AST_DONE_NOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    acc_done |-> !hold_off); // R9
  AST_HOLD_CONT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_phase == PH_HOLD) |=> (acc_phase == PH_HOLD || acc_phase == PH_LAST)); // R9
  AST_WAIT_CONT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_phase == PH_WAIT) |=> (acc_phase != PH_IDLE)); // R11
endmodule

bind bus_wait_gen bwg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .hold_off(hold_off), .acc_done(acc_done), .acc_phase(acc_phase)
);

// File: tb/bus_wait_gen_bench.sv
module bus_wait_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_write = 1'b0, req_mux = 1'b0, req_sfr_slow = 1'b0;
  logic [2:0] req_region = '0;
  logic       hold_off = 1'b0, cfg_we = 1'b0, cfg_int_wait = 1'b0, cfg_sfr_wait = 1'b0;
  logic [7:0] cfg_ext_waits = '0;
  logic       req_ready, acc_done;
  logic [1:0] acc_phase;

  int checks = 0;
  int errors = 0;
  bit ended  = 0;

  always #2 clk = ~clk;

  bus_wait_gen u_bus_wait_gen (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_region(req_region), .req_write(req_write), .req_mux(req_mux),
    .req_sfr_slow(req_sfr_slow), .hold_off(hold_off), .cfg_we(cfg_we),
    .cfg_ext_waits(cfg_ext_waits), .cfg_int_wait(cfg_int_wait),
    .cfg_sfr_wait(cfg_sfr_wait), .acc_done(acc_done), .acc_phase(acc_phase)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [7:0] ext, input logic iw, input logic sw);
    @(negedge clk);
    cfg_ext_waits = ext; cfg_int_wait = iw; cfg_sfr_wait = sw; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Runs one access; len counts cycles from the one after the accepting edge.
  task automatic run_access(input logic [2:0] rgn, input logic wr, input logic mx,
                            input logic slow, input int rel, input bit midcfg,
                            output int len, output int ph1, output int phl);
    int c;
    bit ready_bad;
    ready_bad = 0; ph1 = -1; phl = -1;
    @(negedge clk);
    req_region = rgn; req_write = wr; req_mux = mx; req_sfr_slow = slow;
    req_valid = 1'b1; hold_off = (rel > 0);
    @(negedge clk);
    req_valid = 1'b0;
    c = 1;
    forever begin
      if (c == rel) hold_off = 1'b0;
      if (midcfg && c == 1) begin cfg_ext_waits = '0; cfg_int_wait = 1'b0; cfg_sfr_wait = 1'b0; cfg_we = 1'b1; end
      if (midcfg && c == 2) cfg_we = 1'b0;
      #1;
      if (c == 1) ph1 = int'(acc_phase);
      if (req_ready) ready_bad = 1;
      if (acc_done) begin phl = int'(acc_phase); break; end
      c++;
      if (c > 40) break;
      @(negedge clk);
    end
    len = c;
    cfg_we = 1'b0; hold_off = 1'b0;
    check("R8 ready low during access", int'(ready_bad), 0);
    @(negedge clk); #1;
    check("R8 done single cycle", int'(acc_done), 0);
    check("R8 ready after done", int'(req_ready), 1);
  endtask

  task automatic t_reset();
    int l, p1, pl;
    check("R1 reset ready", int'(req_ready), 1);
    check("R1 reset done", int'(acc_done), 0);
    check("R1 reset phase", int'(acc_phase), 0);
    run_access(3'd2, 0, 0, 0, 0, 0, l, p1, pl); check("R1 default ext len", l, 4);
    run_access(3'd4, 0, 0, 0, 0, 0, l, p1, pl); check("R1 default int len", l, 2);
    run_access(3'd5, 0, 0, 0, 0, 0, l, p1, pl); check("R1 default sfr len", l, 3);
  endtask

  task automatic t_ext_read();
    int l, p1, pl;
    set_cfg(8'b11_10_01_00, 1'b0, 1'b0);
    for (int k = 0; k < 4; k++) begin
      run_access(3'(k), 0, 0, 0, 0, 0, l, p1, pl);
      check("R2 ext read len", l, 1 + k);
    end
    run_access(3'd3, 0, 0, 0, 0, 0, l, p1, pl);
    check("R11 phase wait", p1, 1);
    check("R11 phase last", pl, 3);
  endtask

  task automatic t_ext_write();
    int l, p1, pl;
    run_access(3'd0, 1, 0, 0, 0, 0, l, p1, pl); check("R3 write field0", l, 2);
    run_access(3'd2, 1, 0, 0, 0, 0, l, p1, pl); check("R3 write field2", l, 3);
    run_access(3'd3, 1, 0, 0, 0, 0, l, p1, pl); check("R3 write field3", l, 4);
  endtask

  task automatic t_mux();
    int l, p1, pl;
    run_access(3'd0, 0, 1, 0, 0, 0, l, p1, pl); check("R4 mux field0", l, 3);
    run_access(3'd1, 0, 1, 0, 0, 0, l, p1, pl); check("R4 mux field1", l, 3);
    run_access(3'd3, 0, 1, 0, 0, 0, l, p1, pl); check("R4 mux field3", l, 4);
    run_access(3'd0, 1, 1, 0, 0, 0, l, p1, pl); check("R4 mux write field0", l, 3);
  endtask

  task automatic t_internal();
    int l, p1, pl;
    run_access(3'd4, 0, 0, 0, 0, 0, l, p1, pl); check("R5 int bit0", l, 1);
    run_access(3'd4, 1, 1, 0, 0, 0, l, p1, pl); check("R5 int write mux bit0", l, 1);
    set_cfg(8'b11_10_01_00, 1'b1, 1'b0);
    run_access(3'd4, 0, 0, 0, 0, 0, l, p1, pl); check("R5 int bit1", l, 2);
  endtask

  task automatic t_sfr();
    int l, p1, pl;
    set_cfg(8'b11_10_01_00, 1'b0, 1'b0);
    run_access(3'd5, 0, 0, 0, 0, 0, l, p1, pl); check("R6 sfr bit0", l, 2);
    run_access(3'd5, 0, 0, 1, 0, 0, l, p1, pl); check("R7 slow sfr bit0", l, 3);
    set_cfg(8'b11_10_01_00, 1'b0, 1'b1);
    run_access(3'd5, 1, 0, 0, 0, 0, l, p1, pl); check("R6 sfr bit1", l, 3);
    run_access(3'd5, 0, 0, 1, 0, 0, l, p1, pl); check("R7 slow sfr bit1", l, 3);
  endtask

  task automatic t_reserved();
    int l, p1, pl;
    run_access(3'd6, 1, 1, 0, 0, 0, l, p1, pl); check("R12 region6", l, 1);
    run_access(3'd7, 0, 0, 0, 0, 0, l, p1, pl); check("R12 region7", l, 1);
  endtask

  task automatic t_hold();
    int l, p1, pl;
    set_cfg(8'b11_10_01_00, 1'b0, 1'b0);
    run_access(3'd0, 0, 0, 0, 3, 0, l, p1, pl);
    check("R9 hold zero-wait len", l, 3);
    check("R9 hold phase", p1, 2);
    run_access(3'd1, 0, 0, 0, 4, 0, l, p1, pl);
    check("R9 hold after wait len", l, 4);
    check("R11 wait before hold", p1, 1);
  endtask

  task automatic t_cfg_mid();
    int l, p1, pl;
    set_cfg(8'b11_11_11_11, 1'b1, 1'b1);
    run_access(3'd0, 0, 0, 0, 0, 1, l, p1, pl);
    check("R10 in-flight len kept", l, 4);
    run_access(3'd0, 0, 0, 0, 0, 0, l, p1, pl);
    check("R10 next access new cfg", l, 1);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    t_reset();
    t_ext_read();
    t_ext_write();
    t_mux();
    t_internal();
    t_sfr();
    t_reserved();
    t_hold();
    t_cfg_mid();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule